// File: doc/BRIEF.md
# Clock Alarm Interrupt Flag Generator

The block sits beside a time-of-day counter and turns a fixed base tick (64 per second by default) into interrupt flags. On every base tick it looks at the current hours, minutes and seconds and at three enables. It can raise three kinds of event in that tick:

- **Update:** the seconds value has changed.
- **Periodic:** a programmed number of base ticks has passed.
- **Alarm:** the current time equals a programmed alarm time.

The flags for one tick are packed into a single 16-bit status word. The word also carries a pending bit and an event count. A one-cycle valid strobe marks the word in the cycle after the tick that produced it.

A periodic rate at or below the base rate is set by writing the divider limit as the base rate divided by the requested rate. For example, 16 per second gives a limit of 4. A missed-tick input lets the source of the tick report ticks that were skipped. These are added to the periodic count so that no periodic event is lost, and at most one periodic flag is raised per tick.

Top module: `alarm_flag_gen`

## Requirements
- R1: While reset is held and right after it is released, `flags_o` is 0 and `flags_vld_o` is 0.
- R2: On a tick with update enabled and a valid recorded seconds value, if `sec_i` differs from the recorded value, bit 4 of the word is set and `sec_i` becomes the recorded value.
- R3: In the cycle where `upd_en_i` rises, the recorded seconds value becomes invalid. The next tick with update enabled only records `sec_i` and sets no update flag.
- R4: On each tick with periodic enabled, the periodic count grows by 1 plus `missed_i`. When the result reaches or exceeds `per_limit_i`, bit 6 is set and the count clears; otherwise the count keeps the result. With a limit of L and no missed ticks, the flag fires on every L-th tick.
- R5: The missed-tick addition saturates at the limit, so a single tick raises at most one periodic flag however large `missed_i` is.
- R6: On a tick with alarm enabled and hours, minutes and seconds all equal to the alarm inputs, bit 5 is set.
- R7: Whenever any flag is set, bit 7 (pending) is also set, bits 15:8 hold 1, and bits 3:0 are 0.
- R8: The word and the strobe appear in the cycle after the tick and last one cycle. A cycle whose preceding cycle had no tick, or a tick with no flag, shows word 0 and no strobe.
- R9: With all three enables clear, ticks produce no strobe. While `per_en_i` is low the periodic count is held at zero, so after re-enabling, the first flag comes after a full `per_limit_i` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick strobe, one cycle per tick |
| hour_i | input | 5 | Current hours |
| min_i | input | 6 | Current minutes |
| sec_i | input | 6 | Current seconds |
| upd_en_i | input | 1 | Update event enable |
| per_en_i | input | 1 | Periodic event enable |
| alm_en_i | input | 1 | Alarm event enable |
| per_limit_i | input | 8 | Periodic divider limit in base ticks |
| missed_i | input | 8 | Ticks missed before this tick |
| alm_hour_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| flags_o | output | 16 | Status word: count[15:8], pending[7], periodic[6], alarm[5], update[4] |
| flags_vld_o | output | 1 | Word valid strobe |

## Verification
The assertions check the following on every cycle:
- a strobed word always carries the pending bit and a count of 1;
- a strobe only follows a tick;
- no strobe follows a tick with every enable clear;
- no update flag follows the cycle in which update enable rises;
- the periodic count is zero after a periodic flag.

Only the bench scenarios can show the finer behaviours:
- that a changed seconds value raises the update flag exactly when the recorded value is valid;
- that the divider fires on every L-th tick;
- that a large missed-tick value still yields a single flag;
- that dropping periodic enable restarts the count.

// File: rtl/alarm_flag_pkg.sv
package alarm_flag_pkg;
  localparam int unsigned BASE_TICKS_PER_SEC = 64;
  localparam int unsigned HOUR_W = 5;
  localparam int unsigned MIN_W  = 6;
  localparam int unsigned SEC_W  = 6;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned UPD_BIT  = 4;
  localparam int unsigned ALM_BIT  = 5;
  localparam int unsigned PER_BIT  = 6;
  localparam int unsigned PEND_BIT = 7;
  localparam int unsigned CNT_LSB  = 8;
  localparam logic [7:0]  EVENT_CNT = 8'd1;
endpackage

// File: rtl/upd_detect.sv
module upd_detect #(
  parameter int unsigned SW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [SW-1:0] sec_i,
  output logic          fire_o
);
  logic          en_q, valid_q;
  logic [SW-1:0] last_q;
  logic          rise, seen, differs;

  assign rise    = en_i & ~en_q;
  assign seen    = valid_q & ~rise;
  assign differs = sec_i != last_q;
  assign fire_o  = tick_i & en_i & seen & differs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= '0;
    end else begin
      en_q <= en_i;
      if (rise) valid_q <= 1'b0;
      // first tick after arming records only
      if (tick_i && en_i && (!seen || differs)) begin
        last_q  <= sec_i;
        valid_q <= 1'b1;
      end
    end
  end

  // R2
  fire_records_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (valid_q && last_q == $past(sec_i)));
endmodule

// File: rtl/per_div.sv
module per_div #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  input  logic [CW-1:0] missed_i,
  output logic          fire_o
);
  localparam int unsigned SUM_W = CW + 2;

  logic [CW-1:0]    cnt_q;
  logic [SUM_W-1:0] sum;

  assign sum    = SUM_W'(cnt_q) + SUM_W'(missed_i) + SUM_W'(1);
  // one compare against the limit: saturation, single flag per tick
  assign fire_o = tick_i & en_i & (sum >= SUM_W'(limit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (fire_o)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= sum[CW-1:0];
  end

  // R4
  per_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_q == '0);
  // R9
  per_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/alm_match.sv
module alm_match #(
  parameter int unsigned HW = 5,
  parameter int unsigned MW = 6,
  parameter int unsigned SW = 6
) (
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [HW-1:0] hour_i,
  input  logic [MW-1:0] min_i,
  input  logic [SW-1:0] sec_i,
  input  logic [HW-1:0] alm_hour_i,
  input  logic [MW-1:0] alm_min_i,
  input  logic [SW-1:0] alm_sec_i,
  output logic          fire_o
);
  logic [2:0] eq;
  assign eq[0]  = hour_i == alm_hour_i;
  assign eq[1]  = min_i  == alm_min_i;
  assign eq[2]  = sec_i  == alm_sec_i;
  assign fire_o = tick_i & en_i & (&eq);
endmodule

// File: rtl/alarm_flag_gen.sv
module alarm_flag_gen
  import alarm_flag_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic              upd_en_i,
  input  logic              per_en_i,
  input  logic              alm_en_i,
  input  logic [CW-1:0]     per_limit_i,
  input  logic [CW-1:0]     missed_i,
  input  logic [HOUR_W-1:0] alm_hour_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic [SEC_W-1:0]  alm_sec_i,
  output logic [WORD_W-1:0] flags_o,
  output logic              flags_vld_o
);
  logic f_upd, f_per, f_alm, any_fire;
  logic [WORD_W-1:0] word_d;

  upd_detect #(.SW(SEC_W)) u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(upd_en_i),
    .sec_i(sec_i), .fire_o(f_upd)
  );

  per_div #(.CW(CW)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(per_en_i),
    .limit_i(per_limit_i), .missed_i(missed_i), .fire_o(f_per)
  );

  alm_match #(.HW(HOUR_W), .MW(MIN_W), .SW(SEC_W)) u_alm (
    .tick_i(tick_i), .en_i(alm_en_i), .hour_i(hour_i), .min_i(min_i),
    .sec_i(sec_i), .alm_hour_i(alm_hour_i), .alm_min_i(alm_min_i),
    .alm_sec_i(alm_sec_i), .fire_o(f_alm)
  );

  assign any_fire = f_upd | f_per | f_alm;

  always_comb begin
    word_d = '0;
    word_d[UPD_BIT]  = f_upd;
    word_d[ALM_BIT]  = f_alm;
    word_d[PER_BIT]  = f_per;
    word_d[PEND_BIT] = 1'b1;
    word_d[WORD_W-1:CNT_LSB] = EVENT_CNT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o     <= '0;
      flags_vld_o <= 1'b0;
    end else begin
      flags_vld_o <= any_fire;
      flags_o     <= any_fire ? word_d : '0;
    end
  end

  // R7
  word_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_vld_o |-> (flags_o[15:8] == 8'd1 && flags_o[7] && flags_o[3:0] == 4'd0));
  // R8
  vld_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i == 1'b0 |=> !flags_vld_o && flags_o == '0);
  // R9
  all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_en_i || per_en_i || alm_en_i) |=> !flags_vld_o);
  // R3
  arm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_en_i) |=> !flags_o[UPD_BIT]);
  // R6
  alarm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ALM_BIT] |-> $past(alm_en_i) && $past(sec_i == alm_sec_i));
endmodule

// File: tb/alarm_flag_gen_tb.sv
module alarm_flag_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       tick, upd_en, per_en, alm_en;
  logic [4:0] hour, alm_hour;
  logic [5:0] mins, secs, alm_min, alm_sec;
  logic [7:0] limit, missed;
  logic [15:0] flags;
  logic        vld;

  alarm_flag_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hour_i(hour), .min_i(mins),
    .sec_i(secs), .upd_en_i(upd_en), .per_en_i(per_en), .alm_en_i(alm_en),
    .per_limit_i(limit), .missed_i(missed), .alm_hour_i(alm_hour),
    .alm_min_i(alm_min), .alm_sec_i(alm_sec), .flags_o(flags), .flags_vld_o(vld)
  );

  int n_chk = 0, n_bad = 0;
  // model state
  logic       m_en_prev = 0, m_valid = 0;
  logic [5:0] m_last = 0;
  int         m_cnt = 0;

  function automatic logic [16:0] predict();
    logic u, p, a, rise, seen;
    int s;
    rise = upd_en && !m_en_prev;
    seen = m_valid && !rise;
    u = tick && upd_en && seen && (secs != m_last);
    s = m_cnt + 1 + missed;
    p = tick && per_en && (s >= limit);
    a = tick && alm_en && hour == alm_hour && mins == alm_min && secs == alm_sec;
    m_en_prev = upd_en;
    if (rise) m_valid = 0;
    if (tick && upd_en && (!seen || secs != m_last)) begin m_last = secs; m_valid = 1; end
    if (!per_en || p) m_cnt = 0; else if (tick) m_cnt = s;
    if (u || p || a) return {1'b1, 8'd1, 1'b1, p, a, u, 4'd0};
    return 17'd0;
  endfunction

  task automatic check(string tag, logic [16:0] exp);
    n_chk++;
    if ({vld, flags} !== exp) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b word=%h, expected vld=%0b word=%h",
               tag, vld, flags, exp[16], exp[15:0]);
    end
  endtask

  // inputs already set at negedge; capture, then check at next negedge
  task automatic step(string tag);
    logic [16:0] e;
    e = predict();
    @(posedge clk); @(negedge clk);
    check(tag, e);
  endtask

  task automatic idle_inputs();
    tick = 0; upd_en = 0; per_en = 0; alm_en = 0;
    hour = 0; mins = 0; secs = 0; alm_hour = 5'd3; alm_min = 6'd7; alm_sec = 6'd9;
    limit = 8'd4; missed = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 in reset", 17'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 17'd0);

    // R9: ticks with everything off
    for (int i = 0; i < 4; i++) begin tick = 1; secs = 6'(i); step("R9 all off"); end

    // R3: arm update, first change records only
    upd_en = 1; secs = 6'd10; tick = 1; step("R3 arm tick");
    secs = 6'd11; step("R2 change");
    secs = 6'd11; step("R2 no change");
    tick = 0; secs = 6'd12; step("R8 no tick");
    tick = 1; step("R2 change after idle");
    upd_en = 0; tick = 0; step("R3 disarm");
    upd_en = 1; secs = 6'd20; tick = 1; step("R3 re-arm tick");
    secs = 6'd21; step("R2 after re-arm");
    upd_en = 0;

    // R4: limit 4 = 64/16
    per_en = 1; limit = 8'(64 / 16); tick = 1;
    for (int i = 0; i < 8; i++) step("R4 divide by 4");
    // R5: large missed count, single flag
    missed = 8'd200; step("R5 saturate");
    step("R5 saturate again");
    missed = 8'd2; step("R5 partial");
    missed = 0; step("R5 partial next");
    // R9: drop and re-enable restarts the count
    step("R4 mid count");
    per_en = 0; step("R9 per off");
    per_en = 1;
    for (int i = 0; i < 4; i++) step("R9 restart count");
    per_en = 0;

    // R6: alarm
    alm_en = 1; hour = 5'd3; mins = 6'd7; secs = 6'd9; step("R6 match");
    mins = 6'd8; step("R6 minute differs");
    mins = 6'd7; hour = 5'd4; step("R6 hour differs");
    hour = 5'd3; alm_en = 0; step("R6 disabled");
    alm_en = 1; upd_en = 1; per_en = 1; limit = 1; step("R7 all three arm");
    secs = 6'd9; step("R7 per alarm");
    tick = 0; step("R8 gap");

    // random mix
    idle_inputs();
    for (int i = 0; i < 2000; i++) begin
      tick   = ($urandom_range(0, 3) != 0);
      upd_en = ($urandom_range(0, 7) != 0) ? upd_en : ~upd_en;
      per_en = ($urandom_range(0, 7) != 0) ? per_en : ~per_en;
      alm_en = ($urandom_range(0, 7) != 0) ? alm_en : ~alm_en;
      if ($urandom_range(0, 3) == 0) secs = 6'($urandom_range(0, 3));
      hour = 5'($urandom_range(0, 1)); mins = 6'($urandom_range(0, 1));
      alm_hour = 0; alm_min = 0; alm_sec = 6'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) limit = 8'($urandom_range(1, 6));
      missed = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 255)) : 8'd0;
      step("R2/R4/R5/R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule